// File: doc/BRIEF.md
# Snoop Response and Writeback Buffer Controller

This block is the bus-facing half of one write-back cache on an atomic shared bus. Every bus transaction is presented for one cycle (the address cycle). The controller then looks the address up in its own duplicate copy of the tag and MESI state array, so the processor-side lookups in the primary array never wait for it. It also compares the address with the single-entry write-back buffer. After the lookup it drives this cache's share of three wired-OR bus lines: shared, dirty and inhibit. When it owns the data it signals that the response must come either from the data array or from the buffer. It then applies the MESI state change that the snoop requires.

When the transaction on the bus is this cache's own request, the controller acts as the requester. It waits for the combined inhibit line to fall. It then takes the combined shared line in that same cycle and uses it to pick the state of the fill. Other caches and memory are outside the block. The wired-OR is formed outside it from the outputs of all the caches.

The control is one state machine with four states. IDLE waits for an address cycle. LOOKUP reads the duplicate array and the buffer, and holds inhibit high; it stays in LOOKUP for any cycle in which the processor side writes the duplicate array. REPORT drives the snoop results and waits until the combined inhibit is low. UPDATE writes the new state and stalls processor-side tag writes for that cycle. The transitions are IDLE→LOOKUP on an address cycle, LOOKUP→LOOKUP on a processor tag write, LOOKUP→REPORT otherwise, REPORT→REPORT while the combined inhibit is high, REPORT→UPDATE when it falls, and UPDATE→IDLE.

Top module: `snoop_resp_ctrl`

## Requirements
- R1: After reset, all outputs are low and every duplicate entry is Invalid. A snoop to any address then reports neither shared nor dirty.
- R2: Inhibit is high in the cycle after the address cycle, where `bus_cmd_i` is 0 for a read and 1 for a read-exclusive. It falls in the cycle the lookup finishes. Shared, dirty and both response selects are low whenever inhibit is high.
- R3: In the report phase, shared is high exactly when the snooped tag matches an entry in state S, E or M and `bus_src_i` differs from `CACHE_ID`.
- R4: In the report phase of another cache's request, dirty is high when the block is in state M or sits in the write-back buffer. A state M hit raises `resp_arr_o`. A buffer hit raises `resp_buf_o` instead.
- R5: A snooped read moves M or E to S and leaves S unchanged. A snooped read-exclusive moves any valid copy to I.
- R6: For this cache's own request, `fill_done_o` pulses in the update cycle with `fill_state_o` (I=0, S=1, E=2, M=3). A read fills S if `bus_shared_i` was high in the cycle the combined inhibit was first seen low, and E otherwise. A read-exclusive fills M.
- R7: While `bus_inhibit_i` is high the controller stays in the report phase. It keeps its outputs and makes no state update.
- R8: A buffer load is accepted only when the buffer is empty. `wb_req_o` stays high while an entry is held, and `wb_grant_i` empties the buffer.
- R9: A snoop from another cache that matches the buffered address returns the buffer data on `resp_data_o`, with dirty high and shared low. It then cancels the buffer's pending bus request, so `wb_req_o` is low after the update cycle.
- R10: A processor tag write during the lookup delays the lookup by one cycle, and the lookup then sees the written entry. `cpu_stall_o` is high in the update cycle, and a processor write presented then is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid_i | input | 1 | Address cycle of a bus transaction |
| bus_cmd_i | input | 1 | 0 read, 1 read-exclusive |
| bus_addr_i | input | ADDR_W | Line address (tag above index) |
| bus_src_i | input | SRC_W | Requesting cache number |
| bus_shared_i | input | 1 | Combined shared line |
| bus_inhibit_i | input | 1 | Combined inhibit line |
| snp_shared_o | output | 1 | This cache's shared contribution |
| snp_dirty_o | output | 1 | This cache's dirty contribution |
| snp_inhibit_o | output | 1 | This cache's inhibit contribution |
| resp_arr_o | output | 1 | Data must come from this cache's array |
| resp_buf_o | output | 1 | Data comes from the write-back buffer |
| resp_data_o | output | DATA_W | Buffer data |
| cpu_upd_valid_i | input | 1 | Processor-side duplicate tag write |
| cpu_upd_addr_i | input | ADDR_W | Address of that write |
| cpu_upd_state_i | input | 2 | State written (I=0, S=1, E=2, M=3) |
| cpu_stall_o | output | 1 | Processor tag write refused this cycle |
| wb_load_i | input | 1 | Load an evicted dirty line |
| wb_addr_i | input | ADDR_W | Evicted line address |
| wb_data_i | input | DATA_W | Evicted line data |
| wb_req_o | output | 1 | Buffer requests the bus |
| wb_grant_i | input | 1 | Buffer write-back done |
| fill_done_o | output | 1 | Own request's fill state written |
| fill_state_o | output | 2 | State given to the fill |

## Verification
The in-module properties check several things on every cycle. Inhibit follows each address cycle and is extended by each processor tag write during the lookup. The controller stays in the report phase while the combined inhibit is high. Own requests never drive shared. Dirty always comes with exactly one data source, a buffer hit always ends with the buffer emptied, and each completed fill carries a valid state. The bench scenarios are needed to show what these properties cannot. They show that the state left by each snoop is correct, as seen through the next snoop to the same line. They show that the fill state follows the shared line sampled after inhibit falls. They also show that a full buffer refuses a load and that a processor write made while stalled is lost.

// File: rtl/snp_pkg.sv
package snp_pkg;
    typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_e;
    typedef enum logic [1:0] {PH_IDLE, PH_LOOKUP, PH_REPORT, PH_UPDATE} phase_e;

    // state left behind in this cache by another cache's transaction
    function automatic mesi_e snoop_next(mesi_e cur, logic rdx);
        if (rdx) return ST_I;
        if (cur == ST_M || cur == ST_E) return ST_S;
        return cur;
    endfunction
endpackage

// File: rtl/snp_dup_tags.sv
module snp_dup_tags
    import snp_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [TAG_W-1:0] rd_tag_o,
    output mesi_e            rd_st_o,
    input  logic             we_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [TAG_W-1:0] wr_tag_i,
    input  mesi_e            wr_st_i
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [SETS];
    mesi_e            st_q  [SETS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                tag_q[i] <= '0;
                st_q[i]  <= ST_I;
            end
        end else if (we_i) begin
            tag_q[wr_idx_i] <= wr_tag_i;
            st_q[wr_idx_i]  <= wr_st_i;
        end
    end

    assign rd_tag_o = tag_q[rd_idx_i];
    assign rd_st_o  = st_q[rd_idx_i];
endmodule

// File: rtl/snp_wb_buf.sv
module snp_wb_buf #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              grant_i,
    input  logic              cancel_i,
    input  logic [ADDR_W-1:0] cmp_addr_i,
    output logic              hit_o,
    output logic [DATA_W-1:0] data_o,
    output logic              req_o
);
    logic              valid_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else if (cancel_i || grant_i) begin
            valid_q <= 1'b0;
        end else if (load_i && !valid_q) begin
            valid_q <= 1'b1;
            addr_q  <= load_addr_i;
            data_q  <= load_data_i;
        end
    end

    assign hit_o  = valid_q && (addr_q == cmp_addr_i);
    assign data_o = data_q;
    assign req_o  = valid_q;

    // R8
    wb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !req_o && !cancel_i && !grant_i) |=> req_o);
endmodule

// File: rtl/snp_ctrl.sv
module snp_ctrl
    import snp_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int IDX_W    = 4,
    parameter int SRC_W    = 2,
    parameter int CACHE_ID = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_valid_i,
    input  logic                    bus_cmd_i,
    input  logic [ADDR_W-1:0]       bus_addr_i,
    input  logic [SRC_W-1:0]        bus_src_i,
    input  logic                    bus_shared_i,
    input  logic                    bus_inhibit_i,
    input  logic                    cpu_upd_valid_i,
    input  logic [ADDR_W-IDX_W-1:0] arr_tag_i,
    input  mesi_e                   arr_st_i,
    input  logic                    wb_hit_i,
    output logic [ADDR_W-1:0]       addr_q_o,
    output logic                    shared_o,
    output logic                    dirty_o,
    output logic                    inhibit_o,
    output logic                    resp_arr_o,
    output logic                    resp_buf_o,
    output logic                    cpu_stall_o,
    output logic                    snp_we_o,
    output mesi_e                   snp_st_o,
    output logic                    wb_cancel_o,
    output logic                    fill_done_o,
    output mesi_e                   fill_state_o
);
    localparam int TAG_W = ADDR_W - IDX_W;

    phase_e            ph;
    logic              rdx_q, own_q, buf_q, fill_sh_q;
    logic [ADDR_W-1:0] addr_q;
    mesi_e             hit_st_q;
    logic              tag_eq;

    assign tag_eq   = (arr_tag_i == addr_q[ADDR_W-1:IDX_W]);
    assign addr_q_o = addr_q;

    // state register and captured snoop results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= PH_IDLE;
            rdx_q     <= 1'b0;
            own_q     <= 1'b0;
            buf_q     <= 1'b0;
            fill_sh_q <= 1'b0;
            addr_q    <= '0;
            hit_st_q  <= ST_I;
        end else begin
            unique case (ph)
                PH_IDLE: if (bus_valid_i) begin
                    rdx_q  <= bus_cmd_i;
                    addr_q <= bus_addr_i;
                    own_q  <= (bus_src_i == SRC_W'(CACHE_ID));
                    ph     <= PH_LOOKUP;
                end
                PH_LOOKUP: if (!cpu_upd_valid_i) begin
                    hit_st_q <= tag_eq ? arr_st_i : ST_I;
                    buf_q    <= wb_hit_i;
                    ph       <= PH_REPORT;
                end
                PH_REPORT: if (!bus_inhibit_i) begin
                    fill_sh_q <= bus_shared_i;
                    ph        <= PH_UPDATE;
                end
                PH_UPDATE: ph <= PH_IDLE;
            endcase
        end
    end

    // outputs per state
    always_comb begin
        shared_o     = 1'b0;
        dirty_o      = 1'b0;
        inhibit_o    = 1'b0;
        resp_arr_o   = 1'b0;
        resp_buf_o   = 1'b0;
        cpu_stall_o  = 1'b0;
        snp_we_o     = 1'b0;
        snp_st_o     = ST_I;
        wb_cancel_o  = 1'b0;
        fill_done_o  = 1'b0;
        fill_state_o = ST_I;
        unique case (ph)
            PH_IDLE: ;
            PH_LOOKUP: inhibit_o = 1'b1;
            PH_REPORT: begin
                shared_o   = !own_q && (hit_st_q != ST_I);
                dirty_o    = !own_q && ((hit_st_q == ST_M) || buf_q);
                resp_arr_o = !own_q && (hit_st_q == ST_M) && !buf_q;
                resp_buf_o = !own_q && buf_q;
            end
            PH_UPDATE: begin
                cpu_stall_o = 1'b1;
                if (own_q) begin
                    snp_we_o     = 1'b1;
                    snp_st_o     = rdx_q ? ST_M : (fill_sh_q ? ST_S : ST_E);
                    fill_done_o  = 1'b1;
                    fill_state_o = snp_st_o;
                end else begin
                    snp_we_o    = (hit_st_q != ST_I);
                    snp_st_o    = snoop_next(hit_st_q, rdx_q);
                    wb_cancel_o = buf_q;
                end
            end
        endcase
    end

    // R2
    lookup_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_IDLE && bus_valid_i) |=> inhibit_o);

    // R10
    tag_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_o && cpu_upd_valid_i) |=> inhibit_o);

    // R7
    report_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((shared_o || dirty_o || ph == PH_REPORT) && bus_inhibit_i) |=> (ph == PH_REPORT && !snp_we_o));

    // R3
    own_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_REPORT && own_q) |-> !shared_o);

    // R4
    owner_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_o |-> $onehot({resp_arr_o, resp_buf_o}));

    // R6
    fill_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done_o |-> (fill_state_o != ST_I));
endmodule

// File: rtl/snoop_resp_ctrl.sv
module snoop_resp_ctrl
    import snp_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int IDX_W    = 4,
    parameter int DATA_W   = 16,
    parameter int SRC_W    = 2,
    parameter int CACHE_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid_i,
    input  logic              bus_cmd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [SRC_W-1:0]  bus_src_i,
    input  logic              bus_shared_i,
    input  logic              bus_inhibit_i,
    output logic              snp_shared_o,
    output logic              snp_dirty_o,
    output logic              snp_inhibit_o,
    output logic              resp_arr_o,
    output logic              resp_buf_o,
    output logic [DATA_W-1:0] resp_data_o,
    input  logic              cpu_upd_valid_i,
    input  logic [ADDR_W-1:0] cpu_upd_addr_i,
    input  logic [1:0]        cpu_upd_state_i,
    output logic              cpu_stall_o,
    input  logic              wb_load_i,
    input  logic [ADDR_W-1:0] wb_addr_i,
    input  logic [DATA_W-1:0] wb_data_i,
    output logic              wb_req_o,
    input  logic              wb_grant_i,
    output logic              fill_done_o,
    output logic [1:0]        fill_state_o
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] addr_q;
    logic [TAG_W-1:0]  arr_tag;
    mesi_e             arr_st, snp_st, fill_st;
    logic              snp_we, wb_hit, wb_cancel, cpu_we;
    logic              tag_we;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    mesi_e             wr_st;

    // the snoop side owns the write port in its update cycle
    assign cpu_we = cpu_upd_valid_i && !cpu_stall_o;
    assign tag_we = snp_we || cpu_we;
    assign wr_idx = snp_we ? addr_q[IDX_W-1:0] : cpu_upd_addr_i[IDX_W-1:0];
    assign wr_tag = snp_we ? addr_q[ADDR_W-1:IDX_W] : cpu_upd_addr_i[ADDR_W-1:IDX_W];
    assign wr_st  = snp_we ? snp_st : mesi_e'(cpu_upd_state_i);
    assign fill_state_o = fill_st;

    snp_dup_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx_i (addr_q[IDX_W-1:0]),
        .rd_tag_o (arr_tag),
        .rd_st_o  (arr_st),
        .we_i     (tag_we),
        .wr_idx_i (wr_idx),
        .wr_tag_i (wr_tag),
        .wr_st_i  (wr_st)
    );

    snp_wb_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wb (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (wb_load_i),
        .load_addr_i (wb_addr_i),
        .load_data_i (wb_data_i),
        .grant_i     (wb_grant_i),
        .cancel_i    (wb_cancel),
        .cmp_addr_i  (addr_q),
        .hit_o       (wb_hit),
        .data_o      (resp_data_o),
        .req_o       (wb_req_o)
    );

    snp_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SRC_W(SRC_W), .CACHE_ID(CACHE_ID)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_valid_i     (bus_valid_i),
        .bus_cmd_i       (bus_cmd_i),
        .bus_addr_i      (bus_addr_i),
        .bus_src_i       (bus_src_i),
        .bus_shared_i    (bus_shared_i),
        .bus_inhibit_i   (bus_inhibit_i),
        .cpu_upd_valid_i (cpu_upd_valid_i),
        .arr_tag_i       (arr_tag),
        .arr_st_i        (arr_st),
        .wb_hit_i        (wb_hit),
        .addr_q_o        (addr_q),
        .shared_o        (snp_shared_o),
        .dirty_o         (snp_dirty_o),
        .inhibit_o       (snp_inhibit_o),
        .resp_arr_o      (resp_arr_o),
        .resp_buf_o      (resp_buf_o),
        .cpu_stall_o     (cpu_stall_o),
        .snp_we_o        (snp_we),
        .snp_st_o        (snp_st),
        .wb_cancel_o     (wb_cancel),
        .fill_done_o     (fill_done_o),
        .fill_state_o    (fill_st)
    );

    // R9
    buf_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_buf_o && !bus_inhibit_i) |=> ##1 !wb_req_o);
endmodule

// File: tb/snoop_resp_ctrl_bench.sv
module snoop_resp_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_cmd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [1:0]  bus_src = '0;
    logic        oth_sh = 1'b0, oth_inh = 1'b0;
    logic        bus_sh, bus_inh;
    logic        sh_o, dy_o, inh_o, rarr, rbuf, stall, wb_req, fdone;
    logic [15:0] rdata;
    logic [1:0]  fstate;
    logic        cpu_v = 1'b0;
    logic [11:0] cpu_a = '0;
    logic [1:0]  cpu_s = '0;
    logic        wb_ld = 1'b0, wb_gnt = 1'b0;
    logic [11:0] wb_a = '0;
    logic [15:0] wb_d = '0;
    int          total = 0, bad = 0;
    logic [20:0] v;

    // wired-OR of this cache with the three other modelled caches
    assign bus_sh  = sh_o | oth_sh;
    assign bus_inh = inh_o | oth_inh;

    always #5 clk = ~clk;

    snoop_resp_ctrl u_snoop_resp_ctrl (
        .clk(clk), .rst_n(rst_n),
        .bus_valid_i(bus_valid), .bus_cmd_i(bus_cmd), .bus_addr_i(bus_addr), .bus_src_i(bus_src),
        .bus_shared_i(bus_sh), .bus_inhibit_i(bus_inh),
        .snp_shared_o(sh_o), .snp_dirty_o(dy_o), .snp_inhibit_o(inh_o),
        .resp_arr_o(rarr), .resp_buf_o(rbuf), .resp_data_o(rdata),
        .cpu_upd_valid_i(cpu_v), .cpu_upd_addr_i(cpu_a), .cpu_upd_state_i(cpu_s), .cpu_stall_o(stall),
        .wb_load_i(wb_ld), .wb_addr_i(wb_a), .wb_data_i(wb_d), .wb_req_o(wb_req), .wb_grant_i(wb_gnt),
        .fill_done_o(fdone), .fill_state_o(fstate)
    );

    // {cmd, addr, src, other_shared, exp_shared, exp_dirty, exp_arr, exp_fill}; src 0 is this cache
    localparam int NV = 18;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 12'hA10, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0},
        {1'b0, 12'hA10, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
        {1'b0, 12'hB21, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
        {1'b1, 12'hB21, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
        {1'b0, 12'hB21, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        {1'b0, 12'h772, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        {1'b1, 12'hC32, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
        {1'b0, 12'hC32, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        {1'b0, 12'h555, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1},
        {1'b0, 12'h555, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
        {1'b0, 12'h666, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2},
        {1'b1, 12'h666, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
        {1'b0, 12'h666, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        {1'b1, 12'h447, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3},
        {1'b0, 12'h447, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0},
        {1'b0, 12'h447, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
        {1'b0, 12'hA10, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2},
        {1'b1, 12'hA10, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [11:0] a, input logic [1:0] s);
        @(negedge clk);
        cpu_v = 1'b1; cpu_a = a; cpu_s = s;
        @(negedge clk);
        cpu_v = 1'b0;
    endtask

    // one full transaction; hold = extra cycles the other caches keep inhibit high
    task automatic txn(input logic cmd, input logic [11:0] a, input logic [1:0] src, input logic osh,
                       input int hold, input logic esh, input logic edy, input logic earr,
                       input logic ebuf, input logic [15:0] edata, input logic [1:0] efill);
        @(negedge clk);
        bus_valid = 1'b1; bus_cmd = cmd; bus_addr = a; bus_src = src;
        @(negedge clk);
        bus_valid = 1'b0;
        chk("R2 inhibit in lookup", inh_o, 1);
        chk("R2 quiet in lookup", {sh_o, dy_o, rarr, rbuf}, 0);
        oth_inh = (hold > 0);
        oth_sh  = (hold > 0) ? 1'b0 : osh;
        @(negedge clk);
        chk("R2 inhibit released", inh_o, 0);
        chk("R3 shared", sh_o, esh);
        chk("R4 dirty", dy_o, edy);
        chk("R4 array source", rarr, earr);
        chk("R9 buffer source", rbuf, ebuf);
        if (ebuf) chk("R9 buffer data", rdata, edata);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R7 held in report", {stall, fdone, sh_o, dy_o}, {2'b00, esh, edy});
        end
        oth_inh = 1'b0;
        oth_sh  = osh;
        @(negedge clk);
        chk("R10 stall in update", stall, 1);
        chk("R6 fill pulse", fdone, (src == 2'd0) ? 1 : 0);
        if (src == 2'd0) chk("R6 fill state", fstate, efill);
        oth_sh = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs", {inh_o, sh_o, dy_o, rarr, rbuf, stall, wb_req, fdone}, 0);
        txn(1'b0, 12'h000, 2'd1, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 2'd0);

        // preload duplicate tags (state codes I=0 S=1 E=2 M=3)
        cpu_write(12'hA10, 2'd3);
        cpu_write(12'hB21, 2'd2);
        cpu_write(12'hC32, 2'd1);

        // R3 R4 R5 R6 vector walk
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            txn(v[20], v[19:8], v[7:6], v[5], 0, v[4], v[3], v[2], 1'b0, 16'h0, v[1:0]);
        end

        // R7 R6: fill uses shared sampled after combined inhibit falls
        txn(1'b0, 12'h888, 2'd0, 1'b1, 3, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 2'd1);
        txn(1'b0, 12'h888, 2'd2, 1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 2'd0);
        // R7 hold on a snooped M line
        cpu_write(12'h21D, 2'd3);
        txn(1'b0, 12'h21D, 2'd3, 1'b0, 2, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0, 2'd0);

        // R8 R9 write-back buffer hit and cancel
        @(negedge clk);
        wb_ld = 1'b1; wb_a = 12'h998; wb_d = 16'hBEEF;
        @(negedge clk);
        wb_ld = 1'b0;
        chk("R8 request raised", wb_req, 1);
        txn(1'b0, 12'h998, 2'd2, 1'b0, 0, 1'b0, 1'b1, 1'b0, 1'b1, 16'hBEEF, 2'd0);
        chk("R9 request cancelled", wb_req, 0);

        // R8 R9 mismatch keeps request, grant drains
        @(negedge clk);
        wb_ld = 1'b1; wb_a = 12'h9A9; wb_d = 16'h1234;
        @(negedge clk);
        wb_ld = 1'b0;
        txn(1'b0, 12'h3A9, 2'd1, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 2'd0);
        chk("R9 request kept on mismatch", wb_req, 1);
        @(negedge clk);
        wb_gnt = 1'b1;
        @(negedge clk);
        wb_gnt = 1'b0;
        chk("R8 grant empties", wb_req, 0);

        // R8 load into full buffer is refused
        @(negedge clk);
        wb_ld = 1'b1; wb_a = 12'hBBB; wb_d = 16'h1111;
        @(negedge clk);
        wb_a = 12'hCCB; wb_d = 16'h2222;
        @(negedge clk);
        wb_ld = 1'b0;
        txn(1'b0, 12'hCCB, 2'd1, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 2'd0);
        txn(1'b1, 12'hBBB, 2'd1, 1'b0, 0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h1111, 2'd0);

        // R10 processor tag write during lookup delays it and is seen
        @(negedge clk);
        bus_valid = 1'b1; bus_cmd = 1'b0; bus_addr = 12'h12B; bus_src = 2'd1;
        @(negedge clk);
        bus_valid = 1'b0;
        cpu_v = 1'b1; cpu_a = 12'h12B; cpu_s = 2'd1;
        chk("R10 inhibit at lookup", inh_o, 1);
        @(negedge clk);
        cpu_v = 1'b0;
        chk("R10 lookup extended", inh_o, 1);
        @(negedge clk);
        chk("R10 lookup sees write", sh_o, 1);
        @(negedge clk);
        chk("R10 stall in update", stall, 1);
        cpu_v = 1'b1; cpu_a = 12'h13C; cpu_s = 2'd3;
        @(negedge clk);
        cpu_v = 1'b0;
        txn(1'b0, 12'h13C, 2'd2, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 2'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule